// File: doc/BRIEF.md
# Two-Level Translation Lookaside Lookup Engine

This block answers one question per request: does a virtual address, tagged with the current address-space identifier, have a translation entry, and if so, which one? Entries are kept in two arrays. The first is set-associative and holds small pages. Every entry in it uses a single page size given on an input. The second is fully associative, and each of its entries carries its own page size. Each entry maps an even/odd pair of pages. For that reason the stored page-pair number is compared against the address only above bit `size+1`, and the bits below are masked according to the page size that applies.

A request presented with `req_vld` is answered one clock later with `resp_vld`, a hit flag and a flat entry index. The set-associative array is consulted first. Its set is picked from the address bits just above the page-pair boundary, and all of its ways are compared at once. The fully associative array is consulted only when the first array misses, and then all of its entries are compared at once. A write port loads one entry per cycle at a flat index. The same index space is used for write addresses and for response indices.

A two-state controller produces the response strobe. In state IDLE no response is pending. In state REPLY a response is on the outputs. The transitions are named *accept* (IDLE to REPLY, on a request), *wait* (IDLE to IDLE, no request), *chain* (REPLY to REPLY, a new request while a response is shown) and *drain* (REPLY to IDLE, no new request).

Top module: `tlb2_lookup`

## Requirements
- R1: After reset, no entry exists, `resp_vld` is low, and any lookup misses.
- R2: `resp_vld` is high in exactly the cycle after each cycle in which `req_vld` is high. Back-to-back requests give back-to-back responses.
- R3: With global page size `sa_ps`, the set-associative set is bits [7:0] of `va >> (sa_ps+1)`. A hit in way w, set s reports index w*256 + s.
- R4: An entry whose exist bit is clear never matches.
- R5: An entry matches only if its global bit is set, or if its ASID equals `cur_asid`.
- R6: The stored page-pair number holds VA bits [47:13]. Only its bits at position (ps-12) and above are compared with VA bits [47:ps+1]. Lower address bits and lower stored bits are ignored. The page size must be in 12..29.
- R7: A hit in the set-associative array takes priority over any hit in the fully associative array.
- R8: Fully associative entry i is compared using its own page size and is reported as index 2048 + i.
- R9: When several entries of the same array match, the lowest index is reported.
- R10: On a miss, `resp_hit` is 0 and `resp_idx` is 0.
- R11: A write changes lookup results from the next cycle on. A lookup in the same cycle as the write sees the old contents.
- R12: Write index 0..2047 addresses way `idx[10:8]`, set `idx[7:0]`. Index 2048..2111 addresses fully associative entry `idx-2048`. A write at a higher index changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Lookup request strobe |
| req_va | input | 48 | Virtual address to look up |
| cur_asid | input | 10 | Current address-space identifier |
| sa_ps | input | 6 | Global page size (log2 bytes) of the set-associative array |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 12 | Flat index of the entry written |
| wr_exist | input | 1 | Exist bit written |
| wr_vppn | input | 35 | Page-pair number (VA[47:13]) written |
| wr_ps | input | 6 | Page size written (used by fully associative entries) |
| wr_asid | input | 10 | ASID written |
| wr_glob | input | 1 | Global bit written |
| resp_vld | output | 1 | Response strobe, one cycle after a request |
| resp_hit | output | 1 | An entry matched |
| resp_idx | output | 12 | Flat index of the matching entry, 0 on a miss |

## Verification
The hardest cases to reach are those where the two arrays, or several entries of one array, match the same address at once. Priority and lowest-index selection only show up when that happens. The bench loads two fully associative entries with different page sizes that both cover one address. It then adds a set-associative entry in the set that the address selects, and checks at each step that the reported index moves as expected. Masking is exercised by storing page-pair numbers with nonzero bits below the compare boundary and by setting the low address bits to all ones. A write and a lookup are issued in the same cycle to expose when new contents take effect.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } lk_state_t;

endpackage

// File: rtl/tlb2_match.sv
module tlb2_match #(
    parameter int VPPN_W = 35,
    parameter int ASID_W = 10,
    parameter int PS_W   = 6,
    parameter int LO_BIT = 13
) (
    input  logic [VPPN_W-1:0] va_hi,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [PS_W-1:0]   ps,
    input  logic              ent_e,
    input  logic [VPPN_W-1:0] ent_vppn,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic              ent_g,
    output logic              hit
);

    logic [PS_W:0]       shamt;
    logic [VPPN_W-1:0]   cmp_mask;
    logic                tag_eq;
    logic                asid_ok;

    always_comb begin
        // number of stored low bits below the even/odd page-pair boundary
        shamt    = ({1'b0, ps} + (PS_W+1)'(1)) - (PS_W+1)'(LO_BIT);
        cmp_mask = {VPPN_W{1'b1}} << shamt;
        tag_eq   = (((va_hi ^ ent_vppn) & cmp_mask) == '0);
        asid_ok  = ent_g | (cur_asid == ent_asid);
        hit      = ent_e & asid_ok & tag_eq;
    end

endmodule

// File: rtl/tlb2_sa_array.sv
module tlb2_sa_array #(
    parameter int WAYS   = 8,
    parameter int SETS   = 256,
    parameter int VA_W   = 48,
    parameter int LO_BIT = 13,
    parameter int ASID_W = 10,
    parameter int PS_W   = 6,
    parameter int IDX_W  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [VA_W-1:0]             lk_va,
    input  logic [ASID_W-1:0]           lk_asid,
    input  logic [PS_W-1:0]             lk_ps,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic                        wr_exist,
    input  logic [VA_W-LO_BIT-1:0]      wr_vppn,
    input  logic [ASID_W-1:0]           wr_asid,
    input  logic                        wr_glob,
    output logic                        hit,
    output logic [$clog2(WAYS)+$clog2(SETS)-1:0] hit_idx
);

    localparam int VPPN_W = VA_W - LO_BIT;
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int ADDR_W = WAY_W + SET_W;
    localparam int SA_N   = WAYS * SETS;

    logic [SA_N-1:0]   e_q;
    logic [VPPN_W-1:0] vppn_q [SA_N];
    logic [ASID_W-1:0] asid_q [SA_N];
    logic              g_q    [SA_N];

    logic              wr_sel;
    logic [ADDR_W-1:0] wr_addr;
    logic [VA_W-1:0]   vpn_full;
    logic [SET_W-1:0]  set_idx;
    logic [WAYS-1:0]   way_hit;
    logic [WAY_W-1:0]  hit_way;

    assign wr_sel  = wr_en && (wr_idx < IDX_W'(SA_N));
    assign wr_addr = wr_idx[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else if (wr_sel) begin
            e_q[wr_addr] <= wr_exist;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_sel) begin
            vppn_q[wr_addr] <= wr_vppn;
            asid_q[wr_addr] <= wr_asid;
            g_q[wr_addr]    <= wr_glob;
        end
    end

    // set selection sits just above the page-pair boundary
    assign vpn_full = lk_va >> ({1'b0, lk_ps} + (PS_W+1)'(1));
    assign set_idx  = vpn_full[SET_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [ADDR_W-1:0] rd_addr;
        assign rd_addr = {WAY_W'(w), set_idx};

        tlb2_match #(
            .VPPN_W (VPPN_W),
            .ASID_W (ASID_W),
            .PS_W   (PS_W),
            .LO_BIT (LO_BIT)
        ) u_cmp (
            .va_hi    (lk_va[VA_W-1:LO_BIT]),
            .cur_asid (lk_asid),
            .ps       (lk_ps),
            .ent_e    (e_q[rd_addr]),
            .ent_vppn (vppn_q[rd_addr]),
            .ent_asid (asid_q[rd_addr]),
            .ent_g    (g_q[rd_addr]),
            .hit      (way_hit[w])
        );
    end

    // lowest way wins
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    assign hit_idx = {hit_way, set_idx};

endmodule

// File: rtl/tlb2_fa_array.sv
module tlb2_fa_array #(
    parameter int ENTRIES = 64,
    parameter int BASE    = 2048,
    parameter int VA_W    = 48,
    parameter int LO_BIT  = 13,
    parameter int ASID_W  = 10,
    parameter int PS_W    = 6,
    parameter int IDX_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [VA_W-1:0]            lk_va,
    input  logic [ASID_W-1:0]          lk_asid,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic                       wr_exist,
    input  logic [VA_W-LO_BIT-1:0]     wr_vppn,
    input  logic [PS_W-1:0]            wr_ps,
    input  logic [ASID_W-1:0]          wr_asid,
    input  logic                       wr_glob,
    output logic                       hit,
    output logic [$clog2(ENTRIES)-1:0] hit_idx
);

    localparam int VPPN_W = VA_W - LO_BIT;
    localparam int ENT_W  = $clog2(ENTRIES);

    logic [ENTRIES-1:0] e_q;
    logic [VPPN_W-1:0]  vppn_q [ENTRIES];
    logic [ASID_W-1:0]  asid_q [ENTRIES];
    logic [PS_W-1:0]    ps_q   [ENTRIES];
    logic               g_q    [ENTRIES];

    logic               wr_sel;
    logic [IDX_W-1:0]   wr_off;
    logic [ENT_W-1:0]   wr_addr;
    logic [ENTRIES-1:0] ent_hit;

    assign wr_off  = wr_idx - IDX_W'(BASE);
    assign wr_addr = wr_off[ENT_W-1:0];
    assign wr_sel  = wr_en && (wr_idx >= IDX_W'(BASE)) &&
                     (wr_idx < IDX_W'(BASE + ENTRIES));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else if (wr_sel) begin
            e_q[wr_addr] <= wr_exist;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_sel) begin
            vppn_q[wr_addr] <= wr_vppn;
            asid_q[wr_addr] <= wr_asid;
            ps_q[wr_addr]   <= wr_ps;
            g_q[wr_addr]    <= wr_glob;
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        tlb2_match #(
            .VPPN_W (VPPN_W),
            .ASID_W (ASID_W),
            .PS_W   (PS_W),
            .LO_BIT (LO_BIT)
        ) u_cmp (
            .va_hi    (lk_va[VA_W-1:LO_BIT]),
            .cur_asid (lk_asid),
            .ps       (ps_q[i]),
            .ent_e    (e_q[i]),
            .ent_vppn (vppn_q[i]),
            .ent_asid (asid_q[i]),
            .ent_g    (g_q[i]),
            .hit      (ent_hit[i])
        );
    end

    // lowest entry wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ent_hit[i]) begin
                hit     = 1'b1;
                hit_idx = ENT_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb2_lookup.sv
module tlb2_lookup
    import tlb2_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int LO_BIT  = 13,
    parameter int ASID_W  = 10,
    parameter int PS_W    = 6,
    parameter int SA_WAYS = 8,
    parameter int SA_SETS = 256,
    parameter int FA_N    = 64,
    localparam int SA_N    = SA_WAYS * SA_SETS,
    localparam int TOTAL_N = SA_N + FA_N,
    localparam int IDX_W   = $clog2(TOTAL_N),
    localparam int VPPN_W  = VA_W - LO_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [PS_W-1:0]   sa_ps,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_exist,
    input  logic [VPPN_W-1:0] wr_vppn,
    input  logic [PS_W-1:0]   wr_ps,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    output logic              resp_vld,
    output logic              resp_hit,
    output logic [IDX_W-1:0]  resp_idx
);

    localparam int SA_AW = $clog2(SA_WAYS) + $clog2(SA_SETS);
    localparam int FA_AW = $clog2(FA_N);

    lk_state_t         state_q, state_d;
    logic              sa_hit, fa_hit;
    logic [SA_AW-1:0]  sa_idx;
    logic [FA_AW-1:0]  fa_idx;
    logic              hit_d;
    logic [IDX_W-1:0]  idx_d;

    tlb2_sa_array #(
        .WAYS   (SA_WAYS),
        .SETS   (SA_SETS),
        .VA_W   (VA_W),
        .LO_BIT (LO_BIT),
        .ASID_W (ASID_W),
        .PS_W   (PS_W),
        .IDX_W  (IDX_W)
    ) u_sa (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_va    (req_va),
        .lk_asid  (cur_asid),
        .lk_ps    (sa_ps),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_exist (wr_exist),
        .wr_vppn  (wr_vppn),
        .wr_asid  (wr_asid),
        .wr_glob  (wr_glob),
        .hit      (sa_hit),
        .hit_idx  (sa_idx)
    );

    tlb2_fa_array #(
        .ENTRIES (FA_N),
        .BASE    (SA_N),
        .VA_W    (VA_W),
        .LO_BIT  (LO_BIT),
        .ASID_W  (ASID_W),
        .PS_W    (PS_W),
        .IDX_W   (IDX_W)
    ) u_fa (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_va    (req_va),
        .lk_asid  (cur_asid),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_exist (wr_exist),
        .wr_vppn  (wr_vppn),
        .wr_ps    (wr_ps),
        .wr_asid  (wr_asid),
        .wr_glob  (wr_glob),
        .hit      (fa_hit),
        .hit_idx  (fa_idx)
    );

    // set-associative result shadows the fully associative one
    always_comb begin
        if (sa_hit) begin
            hit_d = 1'b1;
            idx_d = IDX_W'(sa_idx);
        end else if (fa_hit) begin
            hit_d = 1'b1;
            idx_d = IDX_W'(SA_N) + IDX_W'(fa_idx);
        end else begin
            hit_d = 1'b0;
            idx_d = '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_vld ? ST_REPLY : ST_IDLE;   // accept / wait
            ST_REPLY: state_d = req_vld ? ST_REPLY : ST_IDLE;   // chain / drain
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_hit <= 1'b0;
            resp_idx <= '0;
        end else if (req_vld) begin
            resp_hit <= hit_d;
            resp_idx <= idx_d;
        end else begin
            resp_hit <= 1'b0;
            resp_idx <= '0;
        end
    end

    assign resp_vld = (state_q == ST_REPLY);

endmodule

// File: rtl/tlb2_lookup_chk.sv
module tlb2_lookup_chk #(
    parameter int IDX_W   = 12,
    parameter int TOTAL_N = 2112
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic             resp_vld,
    input logic             resp_hit,
    input logic [IDX_W-1:0] resp_idx
);

    // R2
    req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> resp_vld);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !resp_vld);

    // R10
    hit_only_in_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_vld);

    // R10
    miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && !resp_hit) |-> (resp_idx == '0));

    // R12
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (int'(resp_idx) < TOTAL_N));

endmodule

bind tlb2_lookup tlb2_lookup_chk #(
    .IDX_W   (IDX_W),
    .TOTAL_N (TOTAL_N)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .resp_vld (resp_vld),
    .resp_hit (resp_hit),
    .resp_idx (resp_idx)
);

// File: tb/tb_tlb2_lookup.sv
module tb_tlb2_lookup;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_vld;
    logic [47:0] req_va;
    logic [9:0]  cur_asid;
    logic [5:0]  sa_ps;
    logic        wr_en;
    logic [11:0] wr_idx;
    logic        wr_exist;
    logic [34:0] wr_vppn;
    logic [5:0]  wr_ps;
    logic [9:0]  wr_asid;
    logic        wr_glob;
    logic        resp_vld;
    logic        resp_hit;
    logic [11:0] resp_idx;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tlb2_lookup dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_va(req_va),
        .cur_asid(cur_asid), .sa_ps(sa_ps), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_exist(wr_exist), .wr_vppn(wr_vppn), .wr_ps(wr_ps),
        .wr_asid(wr_asid), .wr_glob(wr_glob), .resp_vld(resp_vld),
        .resp_hit(resp_hit), .resp_idx(resp_idx)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] va_of(input logic [34:0] vpn, input int ps);
        return 48'(vpn) << (ps + 1);
    endfunction

    task automatic put(input int idx, input logic e, input logic [34:0] vppn,
                       input int ps, input int asid, input logic g);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 12'(idx); wr_exist = e; wr_vppn = vppn;
        wr_ps = 6'(ps); wr_asid = 10'(asid); wr_glob = g;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_lookup(input logic [47:0] va, input int asid,
                                 input logic eh, input int ei, input string tag);
        @(negedge clk);
        req_vld = 1'b1; req_va = va; cur_asid = 10'(asid);
        @(negedge clk);
        req_vld = 1'b0;
        chk(resp_vld && resp_hit == eh && resp_idx == 12'(eh ? ei : 0), tag,
            {51'd0, resp_vld, resp_hit, resp_idx}, {51'd0, 1'b1, eh, 12'(eh ? ei : 0)});
    endtask

    // R1 R10: empty after reset
    task automatic t_reset;
        chk(resp_vld == 1'b0, "R1 resp_vld low after reset", 64'(resp_vld), 0);
        expect_lookup(va_of(35'h12325, 12), 5, 1'b0, 0, "R1 R10 empty lookup misses");
    endtask

    // R3 R5 R6 set-associative basics
    task automatic t_sa_basic;
        sa_ps = 6'd12;
        put(3*256 + 'h25, 1'b1, 35'h12325, 0, 5, 1'b0);
        expect_lookup(va_of(35'h12325, 12), 5, 1'b1, 805, "R3 way/set index");
        expect_lookup(va_of(35'h12325, 12) | 48'h1FFF, 5, 1'b1, 805, "R6 low VA bits ignored");
        expect_lookup(va_of(35'h12325, 12), 6, 1'b0, 0, "R5 asid mismatch misses");
        put(5*256 + 'h40, 1'b1, 35'h0AB40, 0, 9, 1'b1);
        expect_lookup(va_of(35'h0AB40, 12), 1, 1'b1, 1344, "R5 global ignores asid");
    endtask

    // R4 R11 exist bit and write timing
    task automatic t_exist_timing;
        put('h77, 1'b0, 35'h07777, 0, 5, 1'b0);
        expect_lookup(va_of(35'h07777, 12), 5, 1'b0, 0, "R4 cleared exist bit");
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 12'h077; wr_exist = 1'b1; wr_vppn = 35'h07777;
        wr_asid = 10'd5; wr_glob = 1'b0;
        req_vld = 1'b1; req_va = va_of(35'h07777, 12); cur_asid = 10'd5;
        @(negedge clk);
        wr_en = 1'b0; req_vld = 1'b0;
        chk(resp_vld && !resp_hit, "R11 same-cycle write not seen",
            {62'd0, resp_vld, resp_hit}, 64'h2);
        expect_lookup(va_of(35'h07777, 12), 5, 1'b1, 'h77, "R11 write seen next cycle");
    endtask

    // R3 R6 R9 larger global page size
    task automatic t_sa_ps14;
        sa_ps = 6'd14;
        put(2*256 + 'h10, 1'b1, (35'h31A10 << 2) | 35'h3, 0, 5, 1'b0);
        expect_lookup(va_of(35'h31A10, 14) | 48'h7FFF, 5, 1'b1, 528,
                      "R6 R3 ps14 masked compare");
        put(1*256 + 'h10, 1'b1, 35'h31A10 << 2, 0, 5, 1'b0);
        expect_lookup(va_of(35'h31A10, 14), 5, 1'b1, 272, "R9 lowest way wins");
        sa_ps = 6'd12;
    endtask

    // R8 R9 R7 R5 fully associative part and priorities
    task automatic t_fa;
        put(2048 + 10, 1'b1, 35'h40355, 21, 5, 1'b0);
        expect_lookup(48'h0000_807F_FFFF, 5, 1'b1, 2058, "R8 own page size");
        put(2048 + 3, 1'b1, 35'h403AA, 22, 5, 1'b0);
        expect_lookup(48'h0000_8040_0000, 5, 1'b1, 2051, "R9 lowest fa entry wins");
        put(7*256, 1'b1, 35'h40200, 0, 5, 1'b0);
        expect_lookup(48'h0000_8040_0000, 5, 1'b1, 1792, "R7 set-assoc priority");
        expect_lookup(48'h0000_8040_0000, 6, 1'b0, 0, "R5 R10 asid miss both arrays");
    endtask

    // R12 out-of-range write
    task automatic t_range;
        put(2112 + 5, 1'b1, 35'h60000, 21, 5, 1'b0);
        expect_lookup(48'h0000_C000_0000, 5, 1'b0, 0, "R12 write above range ignored");
    endtask

    // R2 back-to-back requests
    task automatic t_chain;
        @(negedge clk);
        req_vld = 1'b1; req_va = 48'h0000_8040_0000; cur_asid = 10'd5;
        @(negedge clk);
        chk(resp_vld && resp_hit && resp_idx == 12'd1792, "R2 first chained response",
            {51'd0, resp_vld, resp_hit, resp_idx}, {51'd0, 2'b11, 12'd1792});
        req_va = 48'h0000_C000_0000;
        @(negedge clk);
        req_vld = 1'b0;
        chk(resp_vld && !resp_hit, "R2 second chained response",
            {62'd0, resp_vld, resp_hit}, 64'h2);
        @(negedge clk);
        chk(!resp_vld, "R2 response drains", 64'(resp_vld), 0);
    endtask

    initial begin
        rst_n = 1'b0; req_vld = 1'b0; req_va = '0; cur_asid = '0; sa_ps = 6'd12;
        wr_en = 1'b0; wr_idx = '0; wr_exist = 1'b0; wr_vppn = '0; wr_ps = 6'd12;
        wr_asid = '0; wr_glob = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sa_basic();
        t_exist_timing();
        t_sa_ps14();
        t_fa();
        t_range();
        t_chain();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule